// File: doc/BRIEF.md
# Packed Vector Logical Right Shifter

This block shifts every element of a 256-bit packed vector to the right by one common count. The elements are 16, 32 or 64 bits wide and the top of each is filled with zeros. The count comes either from an 8-bit immediate or from the low 64 bits of a 128-bit count operand. If the count is larger than the widest shift that fits in an element, the computed elements are cleared instead of wrapping.

A write-mode input decides what happens to the upper 128 bits of the destination. They can keep the prior destination value supplied with the request, be forced to zero, or be computed like the lower half. One request is taken on each cycle that both valid and ready are high. The result appears on the output register one clock later, together with a single-cycle valid pulse.

Top module: `vsrl_unit`

## Requirements
- R1: With esize = 2'b00, each of the sixteen 16-bit elements is shifted right by the count, with zeros entering at the top of each element.
- R2: With esize = 2'b01, each of the eight 32-bit elements is shifted right by the count with zero fill.
- R3: With esize = 2'b10, each of the four 64-bit elements is shifted right by the count with zero fill.
- R4: A count above 15 (esize 00), above 31 (esize 01) or above 63 (esize 10) makes every computed bit of the result zero.
- R5: With cnt_sel = 1 the count is cnt_vec[63:0], compared over all 64 bits (0x100 clears the result); cnt_vec[127:64] has no effect.
- R6: With cnt_sel = 0 the count is imm_cnt zero-extended to 64 bits; a count of zero passes the source through unchanged.
- R7: With wmode = 2'b00 only bits 127:0 are computed and out_vec[255:128] equals dst_prev[255:128] of the same request.
- R8: With wmode = 2'b01 or 2'b11 bits 127:0 are computed and out_vec[255:128] is zero.
- R9: With wmode = 2'b10 all 256 bits are computed element by element.
- R10: The reserved esize = 2'b11 makes every computed bit of the result zero.
- R11: A request accepted on one rising edge sets out_valid high for exactly the next cycle with its result on out_vec. Without an accepted request, out_valid is low and out_vec holds its value.
- R12: During reset out_valid, out_vec and in_ready are zero; in_ready is high on every cycle after the first edge out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block accepts a request this cycle |
| src_vec | input | 256 | Packed source elements |
| dst_prev | input | 256 | Prior destination value, used for the upper half in preserve mode |
| imm_cnt | input | 8 | Immediate shift count |
| cnt_vec | input | 128 | Count operand; only bits 63:0 count |
| cnt_sel | input | 1 | 1 = count from cnt_vec, 0 = from imm_cnt |
| esize | input | 2 | Element size: 00 = 16, 01 = 32, 10 = 64, 11 = reserved |
| wmode | input | 2 | Upper-half mode: 00 = preserve, 01/11 = zero, 10 = compute |
| out_valid | output | 1 | Result valid pulse |
| out_vec | output | 256 | Registered result |

## Verification
The assertions assume that the request inputs are stable and known around every rising edge while in_valid is high. They also assume that rst_n is held low for at least one edge before the first request. The bench drives all inputs on falling edges only, deasserts in_valid between requests, and holds reset for several cycles. It also draws counts from a mix that puts values on both sides of every element limit, so the range-check assertion is reached from both sides.

// File: rtl/vsrl_pkg.sv
package vsrl_pkg;

    typedef enum logic [1:0] {
        ESZ_16  = 2'b00,
        ESZ_32  = 2'b01,
        ESZ_64  = 2'b10,
        ESZ_RSV = 2'b11
    } esz_e;

    typedef enum logic [1:0] {
        WM_KEEP  = 2'b00,
        WM_CLR   = 2'b01,
        WM_FULL  = 2'b10,
        WM_CLR_B = 2'b11
    } wmode_e;

    // largest legal shift for a given element size, 0 for reserved
    function automatic logic [6:0] max_shift(input logic [1:0] es);
        case (es)
            ESZ_16:  max_shift = 7'd15;
            ESZ_32:  max_shift = 7'd31;
            ESZ_64:  max_shift = 7'd63;
            default: max_shift = 7'd0;
        endcase
    endfunction

endpackage

// File: rtl/vsrl_count.sv
module vsrl_count
    import vsrl_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int OPND_W = 128,
    parameter int IMM_W  = 8,
    parameter int SH_W   = 6
) (
    input  logic              cnt_sel,
    input  logic [IMM_W-1:0]  imm_cnt,
    input  logic [OPND_W-1:0] cnt_vec,
    input  logic [1:0]        esize,
    output logic [SH_W-1:0]   shamt,
    output logic              kill
);
    logic [CNT_W-1:0] cnt_full;
    logic [CNT_W-1:0] limit;
    logic             unused_hi;

    // the upper part of the operand never reaches the count
    assign unused_hi = ^cnt_vec[OPND_W-1:CNT_W];

    always_comb begin
        if (cnt_sel) begin
            cnt_full = cnt_vec[CNT_W-1:0];
        end else begin
            cnt_full = CNT_W'(imm_cnt);
        end
        limit = CNT_W'(max_shift(esize));
        // full-width compare: no truncation of large counts
        kill  = (esize == ESZ_RSV) || (cnt_full > limit);
        shamt = cnt_full[SH_W-1:0];
    end

endmodule

// File: rtl/vsrl_lane.sv
module vsrl_lane
    import vsrl_pkg::*;
#(
    parameter int LANE_W = 64,
    parameter int SH_W   = 6
) (
    input  logic [LANE_W-1:0] d,
    input  logic [SH_W-1:0]   sh,
    input  logic [1:0]        esize,
    input  logic              kill,
    output logic [LANE_W-1:0] q
);
    localparam int N16 = LANE_W / 16;
    localparam int N32 = LANE_W / 32;

    logic [LANE_W-1:0] r16;
    logic [LANE_W-1:0] r32;
    logic [LANE_W-1:0] r64;

    genvar g;
    generate
        for (g = 0; g < N16; g++) begin : g_h
            assign r16[g*16 +: 16] = d[g*16 +: 16] >> sh[3:0];
        end
        for (g = 0; g < N32; g++) begin : g_w
            assign r32[g*32 +: 32] = d[g*32 +: 32] >> sh[4:0];
        end
    endgenerate

    assign r64 = d >> sh;

    always_comb begin
        if (kill) begin
            q = '0;
        end else begin
            case (esize)
                ESZ_16:  q = r16;
                ESZ_32:  q = r32;
                ESZ_64:  q = r64;
                default: q = '0;
            endcase
        end
    end

endmodule

// File: rtl/vsrl_unit.sv
module vsrl_unit
    import vsrl_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 64,
    parameter int CNT_W  = 64,
    parameter int OPND_W = 128,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VEC_W-1:0]  src_vec,
    input  logic [VEC_W-1:0]  dst_prev,
    input  logic [IMM_W-1:0]  imm_cnt,
    input  logic [OPND_W-1:0] cnt_vec,
    input  logic              cnt_sel,
    input  logic [1:0]        esize,
    input  logic [1:0]        wmode,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_vec
);
    localparam int NLANE = VEC_W / LANE_W;
    localparam int HALF  = VEC_W / 2;
    localparam int SH_W  = $clog2(LANE_W);

    typedef struct packed {
        logic             rdy;
        logic             vld;
        logic [VEC_W-1:0] vec;
    } st_t;

    st_t st_d, st_q;

    logic [SH_W-1:0]  shamt;
    logic             kill;
    logic [VEC_W-1:0] shr;
    logic             accept;

    vsrl_count #(
        .CNT_W (CNT_W),
        .OPND_W(OPND_W),
        .IMM_W (IMM_W),
        .SH_W  (SH_W)
    ) u_count (
        .cnt_sel(cnt_sel),
        .imm_cnt(imm_cnt),
        .cnt_vec(cnt_vec),
        .esize  (esize),
        .shamt  (shamt),
        .kill   (kill)
    );

    genvar l;
    generate
        for (l = 0; l < NLANE; l++) begin : g_lane
            vsrl_lane #(
                .LANE_W(LANE_W),
                .SH_W  (SH_W)
            ) u_lane (
                .d    (src_vec[l*LANE_W +: LANE_W]),
                .sh   (shamt),
                .esize(esize),
                .kill (kill),
                .q    (shr[l*LANE_W +: LANE_W])
            );
        end
    endgenerate

    assign accept = in_valid && st_q.rdy;

    always_comb begin
        st_d     = st_q;
        st_d.rdy = 1'b1;
        st_d.vld = accept;
        if (accept) begin
            st_d.vec[HALF-1:0] = shr[HALF-1:0];
            case (wmode)
                WM_KEEP: st_d.vec[VEC_W-1:HALF] = dst_prev[VEC_W-1:HALF];
                WM_FULL: st_d.vec[VEC_W-1:HALF] = shr[VEC_W-1:HALF];
                default: st_d.vec[VEC_W-1:HALF] = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = st_q.rdy;
    assign out_valid = st_q.vld;
    assign out_vec   = st_q.vec;

    AST_KEEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && wmode == WM_KEEP) |=>
            out_vec[VEC_W-1:HALF] == $past(dst_prev[VEC_W-1:HALF])); // R7

    AST_CLR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && wmode[0]) |=> out_vec[VEC_W-1:HALF] == '0); // R8

    AST_BIG_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cnt_sel && cnt_vec[CNT_W-1:0] > CNT_W'(63))
            |=> out_vec[HALF-1:0] == '0); // R4

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && esize == ESZ_RSV) |=> out_vec[HALF-1:0] == '0); // R10

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> (!out_valid && $stable(out_vec))); // R11

endmodule

// File: tb/vsrl_unit_test.sv
module vsrl_unit_test;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] src_vec = '0;
    logic [255:0] dst_prev = '0;
    logic [7:0]   imm_cnt = '0;
    logic [127:0] cnt_vec = '0;
    logic         cnt_sel = 1'b0;
    logic [1:0]   esize = '0;
    logic [1:0]   wmode = '0;
    logic         out_valid;
    logic [255:0] out_vec;

    int checks = 0;
    int errors = 0;
    logic [255:0] last_out;

    always #(CLK_P/2) clk = ~clk;

    vsrl_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_vec(src_vec), .dst_prev(dst_prev), .imm_cnt(imm_cnt),
        .cnt_vec(cnt_vec), .cnt_sel(cnt_sel), .esize(esize), .wmode(wmode),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    function automatic logic [255:0] model(
        input logic [255:0] s, input logic [255:0] p, input logic [7:0] im,
        input logic [127:0] cv, input logic sel, input logic [1:0] es,
        input logic [1:0] wm);
        logic [63:0]  c;
        logic [63:0]  lim;
        logic [255:0] r;
        int ew;
        c   = sel ? cv[63:0] : {56'd0, im};
        lim = (es == 2'b00) ? 64'd15 : (es == 2'b01) ? 64'd31 : 64'd63;
        ew  = 16 << es;
        r   = '0;
        if (es != 2'b11 && c <= lim) begin
            for (int b = 0; b < 256; b++) begin
                if ((b % ew) + int'(c) < ew) r[b] = s[b + int'(c)];
            end
        end
        if (wm == 2'b00) r[255:128] = p[255:128];
        else if (wm != 2'b10) r[255:128] = '0;
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [255:0] got,
                             input logic [255:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // drive one request at a falling edge, check at the next falling edge
    task automatic run_op(input string tag, input logic [255:0] s,
                          input logic [255:0] p, input logic [7:0] im,
                          input logic [127:0] cv, input logic sel,
                          input logic [1:0] es, input logic [1:0] wm);
        logic [255:0] exp;
        exp      = model(s, p, im, cv, sel, es, wm);
        src_vec  = s;  dst_prev = p; imm_cnt = im; cnt_vec = cv;
        cnt_sel  = sel; esize = es; wmode = wm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit({tag, " valid"}, out_valid, 1'b1);
        check_vec(tag, out_vec, exp);
    endtask

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom,
                $urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] a, p;
        void'($urandom(32'd20240611));
        a = rnd256();
        p = rnd256();
        repeat (3) @(negedge clk);
        // R12 reset state
        check_bit("R12 ready in reset", in_ready, 1'b0);
        check_bit("R12 valid in reset", out_valid, 1'b0);
        check_vec("R12 data in reset", out_vec, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R12 ready after reset", in_ready, 1'b1);

        run_op("R1 16b shift 3", a, p, 8'd3, '0, 1'b0, 2'b00, 2'b10);
        run_op("R1 16b shift 15", a, p, 8'd15, '0, 1'b0, 2'b00, 2'b10);
        run_op("R2 32b shift 17", a, p, 8'd17, '0, 1'b0, 2'b01, 2'b10);
        run_op("R3 64b shift 40", a, p, 8'd40, '0, 1'b0, 2'b10, 2'b10);
        run_op("R3 64b shift 63", a, p, 8'd63, '0, 1'b0, 2'b10, 2'b10);
        run_op("R4 16b count 16", a, p, 8'd16, '0, 1'b0, 2'b00, 2'b10);
        run_op("R4 32b count 32", a, p, 8'd32, '0, 1'b0, 2'b01, 2'b10);
        run_op("R4 64b count 64", a, p, 8'd64, '0, 1'b0, 2'b10, 2'b10);
        run_op("R5 high operand ignored", a, p, 8'd0,
               {64'hFFFF_FFFF_FFFF_FFFF, 64'd4}, 1'b1, 2'b01, 2'b10);
        run_op("R5 count 0x100", a, p, 8'd2, {64'd0, 64'h100}, 1'b1, 2'b00, 2'b10);
        run_op("R5 count bit 63", a, p, 8'd2, {64'd0, 64'h8000_0000_0000_0001},
               1'b1, 2'b10, 2'b10);
        run_op("R6 zero count passthrough", a, p, 8'd0, {64'd0, 64'd9},
               1'b0, 2'b10, 2'b10);
        run_op("R6 imm 200 zero-extended", a, p, 8'd200, '0, 1'b0, 2'b10, 2'b10);
        run_op("R7 preserve upper", a, p, 8'd5, '0, 1'b0, 2'b00, 2'b00);
        run_op("R8 clear upper 01", a, p, 8'd5, '0, 1'b0, 2'b01, 2'b01);
        run_op("R8 clear upper 11", a, p, 8'd5, '0, 1'b0, 2'b10, 2'b11);
        run_op("R9 full width", a, p, 8'd7, '0, 1'b0, 2'b01, 2'b10);
        run_op("R10 reserved size", a, p, 8'd1, '0, 1'b0, 2'b11, 2'b10);
        run_op("R10 reserved size preserve", a, p, 8'd0, '0, 1'b0, 2'b11, 2'b00);

        // R11 idle cycles: no pulse, data held
        last_out = out_vec;
        src_vec  = rnd256();
        @(negedge clk);
        check_bit("R11 idle valid low", out_valid, 1'b0);
        check_vec("R11 idle data held", out_vec, last_out);

        for (int i = 0; i < 400; i++) begin
            logic [127:0] cv;
            logic [7:0]   im;
            if ($urandom % 4 == 0) cv = {$urandom, $urandom, $urandom, $urandom};
            else cv = {$urandom, $urandom, 64'($urandom % 70)};
            im = ($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 70);
            run_op("R9 random", rnd256(), rnd256(), im, cv, 1'($urandom),
                   2'($urandom), 2'($urandom));
            if ($urandom % 3 == 0) @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule